// File: doc/BRIEF.md
# Quasi-bidirectional port controller

This block controls a microcontroller-style I/O port of `W` pins (eight by default). Each pin has one latch bit. When the latch bit holds one, the pin behaves as an input that is held high. When it holds zero, the pin is driven low. The block does not model transistors. It produces digital enables for a pull-down driver and for three pull-up devices: a momentary strong boost, a very weak hold-up and a weak feedback hold-up. All pull-up enables are active low.

The CPU side can write a whole byte with `wr_en`, or modify one bit with `bit_en`. A bit modify reads the full latch, changes only the selected bit and writes the whole word back. Either strobe commits at the next clock edge. The drive enables follow the latch one edge later, which models a late latch update and an early output change in the next instruction. There are two read paths, chosen by `rd_sel`. One returns the pin levels after a two-flop synchronizer. The other returns the latch, which is what read-modify-write code needs.

Each pin has its own boost state machine, with states `PU_IDLE`, `PU_HOLD1` and `PU_HOLD2`:
- A trigger occurs when the latch bit is one while the registered drive bit is still zero, that is, on the edge where the drive rises.
- A trigger moves the machine from any state to `PU_HOLD1`. A pulse that is already running therefore restarts.
- With no trigger, `PU_HOLD1` moves to `PU_HOLD2`, `PU_HOLD2` moves to `PU_IDLE`, and `PU_IDLE` stays where it is.
- The boost enable is on in `PU_HOLD1` and `PU_HOLD2`, but only while the drive bit is one.

Top module: `qport_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the latch is all ones. `strong_pu_n` is all ones, `pd_en` is all zeros, `vweak_pu_n` is all zeros, and reading with `rd_sel`=1 returns all ones.
- R2: A byte write (`wr_en`=1) is visible on the latch read path after the commit edge. `pd_en` and `vweak_pu_n` change one edge after that.
- R3: A bit modify (`bit_en`=1) changes only latch bit `bit_sel`. `bit_op` encodings: 0 loads `bit_val`, 1 sets, 2 clears, 3 complements.
- R4: When `wr_en` and `bit_en` are both high, the byte write wins and the latch takes `wr_data` unchanged.
- R5: With `rd_sel`=0, `rd_data` returns `pin_in` two edges after the pin changes. With `rd_sel`=1, `rd_data` returns the latch, whatever the pin level.
- R6: For each bit, `pd_en` is high and `vweak_pu_n` is high when the registered drive bit is zero. Both are low when it is one.
- R7: `weak_pu_n[i]` is low exactly when the synchronized pin bit `i` reads one.
- R8: When a drive bit rises from zero to one, `strong_pu_n` for that bit is low for exactly two cycles and then returns high.
- R9: A new zero-to-one drive transition while a boost is running restarts the two-cycle count.
- R10: `strong_pu_n[i]` is never low while `pd_en[i]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Byte write commit strobe |
| wr_data | input | W | Byte write data |
| bit_en | input | 1 | Single-bit modify commit strobe |
| bit_sel | input | $clog2(W) | Bit index for the modify |
| bit_op | input | 2 | Modify operation (load/set/clear/complement) |
| bit_val | input | 1 | Value used by the load operation |
| rd_sel | input | 1 | 0: synchronized pins, 1: latch |
| rd_data | output | W | Read data |
| pin_in | input | W | Raw pin levels |
| pd_en | output | W | Pull-down enable, active high |
| strong_pu_n | output | W | Boost pull-up enable, active low |
| vweak_pu_n | output | W | Very weak pull-up enable, active low |
| weak_pu_n | output | W | Weak feedback pull-up enable, active low |

## Verification
Two functions can fall in the same cycle on one bit: a fresh boost trigger and a boost that is still running. The bench provokes this by committing set, clear and set to the same bit on three consecutive edges. The drive then rises, falls and rises again while the state machine is still in `PU_HOLD2`. The check has three parts. `strong_pu_n` must be released during the low-drive cycle, with no overlap with `pd_en`. It must then be low for a full two cycles after the second rise, not cut short by the old count. Finally it must return high.

// File: rtl/qport_pkg.sv
package qport_pkg;

    typedef enum logic [1:0] {
        BOP_LOAD = 2'd0,
        BOP_SET  = 2'd1,
        BOP_CLR  = 2'd2,
        BOP_TGL  = 2'd3
    } bitop_e;

    typedef enum logic [1:0] {
        PU_IDLE  = 2'd0,
        PU_HOLD1 = 2'd1,
        PU_HOLD2 = 2'd2
    } pu_state_e;

endpackage

// File: rtl/qport_sync.sv
module qport_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    // Pins idle high, so both stages reset to one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            q      <= '1;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/qport_latch.sv
module qport_latch
    import qport_pkg::*;
#(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             bit_en,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic [1:0]       bit_op,
    input  logic             bit_val,
    output logic [W-1:0]     latch_q,
    output logic [W-1:0]     drive_q
);

    bitop_e       op;
    logic         cur_bit;
    logic         new_bit;
    logic [W-1:0] latch_d;

    assign op      = bitop_e'(bit_op);
    assign cur_bit = latch_q[bit_sel];

    always_comb begin
        unique case (op)
            BOP_LOAD: new_bit = bit_val;
            BOP_SET:  new_bit = 1'b1;
            BOP_CLR:  new_bit = 1'b0;
            BOP_TGL:  new_bit = ~cur_bit;
        endcase
    end

    // The whole word is read back and rewritten; a byte write has priority.
    always_comb begin
        latch_d = latch_q;
        if (wr_en) begin
            latch_d = wr_data;
        end else if (bit_en) begin
            latch_d[bit_sel] = new_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else if (wr_en || bit_en) begin
            latch_q <= latch_d;
        end
    end

    // The pin drive follows the latch one edge later.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '1;
        end else begin
            drive_q <= latch_q;
        end
    end

endmodule

// File: rtl/qport_boost.sv
module qport_boost
    import qport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic latch_bit,
    input  logic drive_bit,
    output logic boost_on
);

    pu_state_e state_q;
    pu_state_e state_d;
    logic      trig;

    // The drive register takes the latch value at this edge: a rising drive.
    assign trig = latch_bit & ~drive_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PU_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PU_IDLE:  state_d = trig ? PU_HOLD1 : PU_IDLE;
            PU_HOLD1: state_d = trig ? PU_HOLD1 : PU_HOLD2;
            PU_HOLD2: state_d = trig ? PU_HOLD1 : PU_IDLE;
            default:  state_d = PU_IDLE;
        endcase
    end

    // Never boost against the pull-down.
    always_comb begin
        unique case (state_q)
            PU_HOLD1, PU_HOLD2: boost_on = drive_bit;
            default:            boost_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/qport_ctrl.sv
module qport_ctrl
    import qport_pkg::*;
#(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             bit_en,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic [1:0]       bit_op,
    input  logic             bit_val,
    input  logic             rd_sel,
    output logic [W-1:0]     rd_data,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pd_en,
    output logic [W-1:0]     strong_pu_n,
    output logic [W-1:0]     vweak_pu_n,
    output logic [W-1:0]     weak_pu_n
);

    logic [W-1:0] latch_q;
    logic [W-1:0] drive_q;
    logic [W-1:0] pin_s;
    logic [W-1:0] boost;

    qport_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    qport_latch #(.W(W), .SEL_W(SEL_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .bit_en  (bit_en),
        .bit_sel (bit_sel),
        .bit_op  (bit_op),
        .bit_val (bit_val),
        .latch_q (latch_q),
        .drive_q (drive_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_boost
        qport_boost u_boost (
            .clk       (clk),
            .rst_n     (rst_n),
            .latch_bit (latch_q[i]),
            .drive_bit (drive_q[i]),
            .boost_on  (boost[i])
        );
    end

    assign rd_data     = rd_sel ? latch_q : pin_s;
    assign pd_en       = ~drive_q;
    assign vweak_pu_n  = ~drive_q;
    assign strong_pu_n = ~boost;
    assign weak_pu_n   = ~pin_s;

endmodule

// File: rtl/qport_chk.sv
module qport_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         bit_en,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] pd_en,
    input logic [W-1:0] vweak_pu_n,
    input logic [W-1:0] strong_pu_n
);

    p_byte_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (latch_q == $past(wr_data)));

    p_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !wr_en) |=> ($countones(latch_q ^ $past(latch_q)) <= 1));

    p_drive_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pd_en == ~$past(latch_q));

    for (genvar i = 0; i < W; i++) begin : g_bit
        p_no_fight_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(pd_en[i] && !strong_pu_n[i]));

        p_boost_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(vweak_pu_n[i]) |-> !strong_pu_n[i]);

        p_boost_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(!strong_pu_n[i] && !$past(strong_pu_n[i]) && !$past(strong_pu_n[i], 2)
              && !$fell(vweak_pu_n[i])));
    end

endmodule

bind qport_ctrl qport_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .bit_en      (bit_en),
    .latch_q     (latch_q),
    .pd_en       (pd_en),
    .vweak_pu_n  (vweak_pu_n),
    .strong_pu_n (strong_pu_n)
);

// File: tb/test_qport_ctrl.sv
module test_qport_ctrl;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         bit_en = 1'b0;
    logic [2:0]   bit_sel = '0;
    logic [1:0]   bit_op = '0;
    logic         bit_val = 1'b0;
    logic         rd_sel = 1'b1;
    logic [W-1:0] rd_data;
    logic [W-1:0] pin_in = '1;
    logic [W-1:0] pd_en;
    logic [W-1:0] strong_pu_n;
    logic [W-1:0] vweak_pu_n;
    logic [W-1:0] weak_pu_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    qport_ctrl #(.W(W)) i_qport_ctrl (
        .clk, .rst_n, .wr_en, .wr_data, .bit_en, .bit_sel, .bit_op, .bit_val,
        .rd_sel, .rd_data, .pin_in, .pd_en, .strong_pu_n, .vweak_pu_n, .weak_pu_n
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_byte(logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bit_mod(logic [2:0] sel, logic [1:0] op, logic v);
        @(negedge clk);
        bit_en = 1'b1; bit_sel = sel; bit_op = op; bit_val = v;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 latch in reset", rd_data, 8'hFF);
        chk("R1 strong in reset", strong_pu_n, 8'hFF);
        @(negedge clk); rst_n = 1'b1;
        settle(2);
        chk("R1 latch", rd_data, 8'hFF);
        chk("R1 strong", strong_pu_n, 8'hFF);
        chk("R1 pd_en", pd_en, 8'h00);
        chk("R1 vweak", vweak_pu_n, 8'h00);
    endtask

    task automatic t_byte;
        rd_sel = 1'b1;
        wr_byte(8'hA5);
        chk("R2 latch after commit", rd_data, 8'hA5);
        chk("R2 drive not yet", pd_en, 8'h00);
        @(negedge clk);
        chk("R2 R6 pd_en", pd_en, 8'h5A);
        chk("R6 vweak", vweak_pu_n, 8'h5A);
        settle(3);
    endtask

    task automatic t_bitops;
        bit_mod(3'd1, 2'd1, 1'b0); chk("R3 set", rd_data, 8'hA7);
        bit_mod(3'd7, 2'd2, 1'b1); chk("R3 clear", rd_data, 8'h27);
        bit_mod(3'd0, 2'd3, 1'b0); chk("R3 toggle", rd_data, 8'h26);
        bit_mod(3'd4, 2'd0, 1'b1); chk("R3 load", rd_data, 8'h36);
        settle(3);
    endtask

    task automatic t_priority;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h3C;
        bit_en = 1'b1; bit_sel = 3'd0; bit_op = 2'd1;
        @(negedge clk);
        wr_en = 1'b0; bit_en = 1'b0;
        chk("R4 byte wins", rd_data, 8'h3C);
        wr_byte(8'h36);
        settle(3);
    endtask

    task automatic t_read;
        pin_in = 8'h0F; rd_sel = 1'b0;
        @(negedge clk);
        chk("R5 pin one edge", rd_data, 8'hFF);
        @(negedge clk);
        chk("R5 pin two edges", rd_data, 8'h0F);
        chk("R7 weak feedback", weak_pu_n, 8'hF0);
        rd_sel = 1'b1;
        #0;
        chk("R5 latch path ignores pin", rd_data, 8'h36);
        pin_in = 8'hFF;
        settle(3);
    endtask

    task automatic t_boost;
        bit_mod(3'd2, 2'd2, 1'b0);
        settle(3);
        chk("R8 idle before rise", strong_pu_n, 8'hFF);
        bit_mod(3'd2, 2'd1, 1'b0);
        chk("R8 not before drive", strong_pu_n, 8'hFF);
        @(negedge clk); chk("R8 cycle 1", strong_pu_n, 8'hFB);
        @(negedge clk); chk("R8 cycle 2", strong_pu_n, 8'hFB);
        @(negedge clk); chk("R8 released", strong_pu_n, 8'hFF);
        settle(2);
    endtask

    task automatic t_retrigger;
        @(negedge clk);
        bit_en = 1'b1; bit_sel = 3'd6; bit_op = 2'd1;
        @(negedge clk);
        chk("R9 before rise", strong_pu_n, 8'hFF);
        bit_op = 2'd2;
        @(negedge clk);
        chk("R9 first rise", strong_pu_n, 8'hBF);
        bit_op = 2'd1;
        @(negedge clk);
        bit_en = 1'b0;
        chk("R10 released under pull-down", strong_pu_n, 8'hFF);
        chk("R10 pull-down on", pd_en & 8'h40, 8'h40);
        @(negedge clk); chk("R9 restart cycle 1", strong_pu_n, 8'hBF);
        @(negedge clk); chk("R9 restart cycle 2", strong_pu_n, 8'hBF);
        @(negedge clk); chk("R9 released", strong_pu_n, 8'hFF);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        settle(3);
        t_reset;
        t_byte;
        t_bitops;
        t_priority;
        t_read;
        t_boost;
        t_retrigger;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule